// File: doc/BRIEF.md
# I2C Event Flag Unit

This block holds the event flags of a byte-oriented I2C controller that can act as bus master or slave, sending or receiving. A bit engine reports single-cycle events: a start condition was issued, the own slave address was recognised, the master's address byte went out, a byte finished, the peer did not acknowledge, or a stop condition appeared on the bus. The CPU clears most of these flags with an ordered pair of register accesses instead of a write-one-to-clear. The unit watches the CPU's register accesses to recognise those pairs.

A read of status register A arms a two-step clear. The access that follows it decides which armed flags drop: a data write, a data read or a control write. Any other access in between disarms the sequence. A summary flag is the OR of all flags, and an interrupt line follows it when interrupts are enabled. There is one special case. The controller can release the bus after a not-acknowledged byte by pulsing its stop control bit. That clears the pending byte flag and hides the stop condition that follows.

Top module: `i2c_evflags`

## Requirements
- R1: With `rst` high at a clock edge, all six flags, `evt_any` and `irq` are 0 after that edge, and no clear sequence is armed.
- R2: An event pulse sets its flag at the next clock edge. A set arriving in the same cycle as a clear of that flag wins, so the flag stays 1.
- R3: `evt_any` is the OR of `flag_start`, `flag_addr_hit`, `flag_byte_done`, `flag_nack`, `flag_stop` and `flag_addr_sent`. `irq` equals `evt_any` AND `irq_en`.
- R4: A `rd_stat_a` access clears `flag_addr_hit` and `flag_nack` at that edge.
- R5: `flag_start` clears only when a `rd_stat_a` access is followed, as the next access, by `wr_data`.
- R6: With `mode_rx`=1, `flag_byte_done` clears on `rd_stat_a` followed by `rd_data`. With `mode_rx`=0, it clears on `rd_stat_a` followed by `wr_data`. The wrong kind of data access leaves it set.
- R7: `flag_addr_sent` clears on `rd_stat_a` followed by `wr_ctrl`.
- R8: Between the read and the completing access, any other access disarms the sequence. A later qualifying access then clears nothing. A completion clears only flags that were 1 at the time of the `rd_stat_a` read.
- R9: Once `flag_byte_done` and `flag_nack` have been 1 together, `flag_byte_done` also clears on a `wr_data` without any arming read. It also clears on a 1-to-0 transition of `stop_ctl`.
- R10: A stop condition that follows a bus release by the `stop_ctl` transition does not set `flag_stop`. The next stop condition after that one sets it again. `flag_stop` clears on `rd_stat_b`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_start_sent | input | 1 | Pulse: master issued a start condition |
| ev_addr_match | input | 1 | Pulse: own slave address recognised |
| ev_addr_sent | input | 1 | Pulse: master address phase complete |
| ev_byte_done | input | 1 | Pulse: byte transfer finished |
| ev_ack_fail | input | 1 | Pulse: no acknowledge received |
| ev_stop_seen | input | 1 | Pulse: stop condition detected |
| mode_rx | input | 1 | 1 = receiving data, 0 = transmitting |
| stop_ctl | input | 1 | Level of the stop control bit |
| irq_en | input | 1 | Interrupt enable |
| rd_stat_a | input | 1 | CPU read of status register A |
| rd_stat_b | input | 1 | CPU read of status register B |
| rd_data | input | 1 | CPU read of the data register |
| wr_data | input | 1 | CPU write of the data register |
| wr_ctrl | input | 1 | CPU write of the control register |
| flag_start | output | 1 | Start issued flag |
| flag_addr_hit | output | 1 | Own address matched flag |
| flag_byte_done | output | 1 | Byte finished flag |
| flag_nack | output | 1 | Acknowledge failure flag |
| flag_stop | output | 1 | Stop detected flag |
| flag_addr_sent | output | 1 | Master address phase flag |
| evt_any | output | 1 | Summary of all flags |
| irq | output | 1 | Interrupt request |

## Verification
The hidden state here is the armed bit, the snapshot taken at the status read, the release hold and the stop suppression. A wrong arming state shows at the ports on the edge of the completing access: a flag stays high after a correct pair, or drops after a broken pair. A wrong suppression state shows on the edge of the stop pulse. A wrong hold state shows on the edge of the bare data write or the stop control transition. Each error is therefore visible one cycle after the access or event that exposes it.

// File: rtl/i2c_evflags_pkg.sv
package i2c_evflags_pkg;

    typedef struct packed {
        logic start;
        logic addr_hit;
        logic byte_done;
        logic nack;
        logic stop;
        logic addr_sent;
    } flags_t;

    typedef struct packed {
        logic rd_a;
        logic rd_b;
        logic rd_d;
        logic wr_d;
        logic wr_c;
    } access_t;

    // flags that need the two-step sequence
    typedef struct packed {
        logic start;
        logic byte_done;
        logic addr_sent;
    } seq_mask_t;

    localparam flags_t FLAGS_NONE = '0;

    function automatic logic any_flag(flags_t f);
        return |f;
    endfunction

    // any access other than the arming read
    function automatic logic other_access(access_t a);
        return a.rd_b | a.rd_d | a.wr_d | a.wr_c;
    endfunction

endpackage

// File: rtl/i2c_evflags_seq.sv
module i2c_evflags_seq
    import i2c_evflags_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  access_t   acc,
    input  flags_t    cur,
    input  logic      mode_rx,
    output seq_mask_t done
);
    logic      arm_q;
    seq_mask_t snap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            arm_q  <= 1'b0;
            snap_q <= '0;
        end else if (acc.rd_a) begin
            arm_q  <= 1'b1;
            snap_q <= '{start: cur.start, byte_done: cur.byte_done,
                        addr_sent: cur.addr_sent};
        end else if (other_access(acc)) begin
            arm_q  <= 1'b0;
        end
    end

    always_comb begin
        done.start     = arm_q & snap_q.start & acc.wr_d;
        done.byte_done = arm_q & snap_q.byte_done &
                         (mode_rx ? acc.rd_d : acc.wr_d);
        done.addr_sent = arm_q & snap_q.addr_sent & acc.wr_c;
    end
endmodule

// File: rtl/i2c_evflags_regs.sv
module i2c_evflags_regs
    import i2c_evflags_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  flags_t    set_ev,
    input  access_t   acc,
    input  seq_mask_t done,
    input  logic      stop_ctl,
    output flags_t    flags
);
    flags_t flags_q;
    flags_t clr;
    logic   hold_q;
    logic   supp_q;
    logic   stop_d;
    logic   stop_fall;
    logic   stop_set;

    assign stop_fall = stop_d & ~stop_ctl;
    assign stop_set  = set_ev.stop & ~supp_q;

    always_comb begin
        clr           = FLAGS_NONE;
        clr.start     = done.start;
        clr.addr_hit  = acc.rd_a;
        clr.nack      = acc.rd_a;
        clr.byte_done = done.byte_done | (hold_q & (acc.wr_d | stop_fall));
        clr.stop      = acc.rd_b;
        clr.addr_sent = done.addr_sent;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= FLAGS_NONE;
            hold_q  <= 1'b0;
            supp_q  <= 1'b0;
            stop_d  <= 1'b0;
        end else begin
            stop_d              <= stop_ctl;
            flags_q.start       <= set_ev.start     | (flags_q.start     & ~clr.start);
            flags_q.addr_hit    <= set_ev.addr_hit  | (flags_q.addr_hit  & ~clr.addr_hit);
            flags_q.byte_done   <= set_ev.byte_done | (flags_q.byte_done & ~clr.byte_done);
            flags_q.nack        <= set_ev.nack      | (flags_q.nack      & ~clr.nack);
            flags_q.stop        <= stop_set         | (flags_q.stop      & ~clr.stop);
            flags_q.addr_sent   <= set_ev.addr_sent | (flags_q.addr_sent & ~clr.addr_sent);
            if (set_ev.byte_done)
                hold_q <= hold_q;
            else if (clr.byte_done)
                hold_q <= 1'b0;
            else if (flags_q.byte_done & flags_q.nack)
                hold_q <= 1'b1;
            if (set_ev.stop)
                supp_q <= 1'b0;
            else if (hold_q & stop_fall & ~set_ev.byte_done)
                supp_q <= 1'b1;
        end
    end

    assign flags = flags_q;
endmodule

// File: rtl/i2c_evflags.sv
module i2c_evflags
    import i2c_evflags_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ev_start_sent,
    input  logic ev_addr_match,
    input  logic ev_addr_sent,
    input  logic ev_byte_done,
    input  logic ev_ack_fail,
    input  logic ev_stop_seen,
    input  logic mode_rx,
    input  logic stop_ctl,
    input  logic irq_en,
    input  logic rd_stat_a,
    input  logic rd_stat_b,
    input  logic rd_data,
    input  logic wr_data,
    input  logic wr_ctrl,
    output logic flag_start,
    output logic flag_addr_hit,
    output logic flag_byte_done,
    output logic flag_nack,
    output logic flag_stop,
    output logic flag_addr_sent,
    output logic evt_any,
    output logic irq
);
    flags_t    set_ev;
    flags_t    flags;
    access_t   acc;
    seq_mask_t done;

    assign set_ev = '{start: ev_start_sent, addr_hit: ev_addr_match,
                      byte_done: ev_byte_done, nack: ev_ack_fail,
                      stop: ev_stop_seen, addr_sent: ev_addr_sent};
    assign acc    = '{rd_a: rd_stat_a, rd_b: rd_stat_b, rd_d: rd_data,
                      wr_d: wr_data, wr_c: wr_ctrl};

    i2c_evflags_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .acc     (acc),
        .cur     (flags),
        .mode_rx (mode_rx),
        .done    (done)
    );

    i2c_evflags_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .set_ev   (set_ev),
        .acc      (acc),
        .done     (done),
        .stop_ctl (stop_ctl),
        .flags    (flags)
    );

    assign flag_start     = flags.start;
    assign flag_addr_hit  = flags.addr_hit;
    assign flag_byte_done = flags.byte_done;
    assign flag_nack      = flags.nack;
    assign flag_stop      = flags.stop;
    assign flag_addr_sent = flags.addr_sent;
    assign evt_any        = any_flag(flags);
    assign irq            = evt_any & irq_en;
endmodule

// File: rtl/i2c_evflags_chk.sv
module i2c_evflags_chk (
    input logic clk,
    input logic rst,
    input logic ev_start_sent,
    input logic ev_addr_match,
    input logic ev_stop_seen,
    input logic irq_en,
    input logic rd_stat_a,
    input logic rd_stat_b,
    input logic wr_data,
    input logic wr_ctrl,
    input logic flag_start,
    input logic flag_addr_hit,
    input logic flag_stop,
    input logic flag_addr_sent,
    input logic evt_any,
    input logic irq
);
    logic rst_seen;
    always_ff @(posedge clk) rst_seen <= rst;

    // R1
    always_ff @(posedge clk)
        if (rst_seen) a_r1_reset_clears: assert (!evt_any && !irq);

    a_r2_start_sets: assert property (@(posedge clk) disable iff (rst)
        ev_start_sent |=> flag_start);

    a_r3_irq_gate: assert property (@(posedge clk) disable iff (rst)
        irq |-> (irq_en && evt_any));

    a_r4_addr_hit_clear: assert property (@(posedge clk) disable iff (rst)
        (rd_stat_a && !ev_addr_match) |=> !flag_addr_hit);

    a_r5_start_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(flag_start) |-> $past(wr_data));

    a_r7_addr_sent_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(flag_addr_sent) |-> $past(wr_ctrl));

    a_r10_stop_clear: assert property (@(posedge clk) disable iff (rst)
        (rd_stat_b && !ev_stop_seen) |=> !flag_stop);
endmodule

bind i2c_evflags i2c_evflags_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .ev_start_sent  (ev_start_sent),
    .ev_addr_match  (ev_addr_match),
    .ev_stop_seen   (ev_stop_seen),
    .irq_en         (irq_en),
    .rd_stat_a      (rd_stat_a),
    .rd_stat_b      (rd_stat_b),
    .wr_data        (wr_data),
    .wr_ctrl        (wr_ctrl),
    .flag_start     (flag_start),
    .flag_addr_hit  (flag_addr_hit),
    .flag_stop      (flag_stop),
    .flag_addr_sent (flag_addr_sent),
    .evt_any        (evt_any),
    .irq            (irq)
);

// File: tb/i2c_evflags_tb.sv
module i2c_evflags_tb;
    logic clk = 1'b0;
    logic rst;
    logic ev_start_sent, ev_addr_match, ev_addr_sent, ev_byte_done, ev_ack_fail, ev_stop_seen;
    logic mode_rx, stop_ctl, irq_en;
    logic rd_stat_a, rd_stat_b, rd_data, wr_data, wr_ctrl;
    logic flag_start, flag_addr_hit, flag_byte_done, flag_nack, flag_stop, flag_addr_sent;
    logic evt_any, irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    i2c_evflags u_dut (.*);

    // flag vector order: {start, addr_hit, byte_done, nack, stop, addr_sent}
    function automatic logic [5:0] fv();
        return {flag_start, flag_addr_hit, flag_byte_done, flag_nack, flag_stop, flag_addr_sent};
    endfunction

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    task automatic chk_all(input string req, input logic [5:0] exp);
        chk(req, {fv(), evt_any, irq}, {exp, |exp, (|exp) & irq_en});
    endtask

    task automatic idle_inputs();
        {ev_start_sent, ev_addr_match, ev_addr_sent, ev_byte_done, ev_ack_fail, ev_stop_seen} = '0;
        {rd_stat_a, rd_stat_b, rd_data, wr_data, wr_ctrl} = '0;
    endtask

    // one cycle with selected strobes; returns at the next negedge
    task automatic ev(input logic [5:0] e);
        {ev_start_sent, ev_addr_match, ev_byte_done, ev_ack_fail, ev_stop_seen, ev_addr_sent} = e;
        @(negedge clk);
        idle_inputs();
    endtask

    // access code: 0 rd_a, 1 rd_b, 2 rd_d, 3 wr_d, 4 wr_c
    task automatic acc(input int k);
        rd_stat_a = (k == 0);
        rd_stat_b = (k == 1);
        rd_data   = (k == 2);
        wr_data   = (k == 3);
        wr_ctrl   = (k == 4);
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        ev(6'b111111);
        do_reset();
        chk_all("R1 reset", 6'b000000);
    endtask

    task automatic t_master_tx();
        mode_rx = 1'b0;
        ev(6'b100000);
        chk_all("R2 start set", 6'b100000);
        acc(0);
        chk_all("R5 start held after read only", 6'b100000);
        acc(3);
        chk_all("R5 start cleared", 6'b000000);
        ev(6'b000001);
        chk("R3 irq on address event", {7'b0, irq}, {7'b0, irq_en});
        acc(0);
        acc(4);
        chk_all("R7 address event cleared", 6'b000000);
        ev(6'b001000);
        acc(0);
        acc(2);
        chk_all("R6 tx byte not cleared by read", 6'b001000);
        acc(3);
        chk_all("R8 disarmed write clears nothing", 6'b001000);
        acc(0);
        acc(3);
        chk_all("R6 tx byte cleared", 6'b000000);
    endtask

    task automatic t_master_rx();
        mode_rx = 1'b1;
        ev(6'b001000);
        acc(0);
        acc(3);
        chk_all("R6 rx byte not cleared by write", 6'b001000);
        acc(0);
        acc(1);
        acc(2);
        chk_all("R8 read-B disarms", 6'b001000);
        acc(0);
        acc(2);
        chk_all("R6 rx byte cleared", 6'b000000);
    endtask

    task automatic t_slave_rx();
        mode_rx = 1'b1;
        ev(6'b010000);
        chk_all("R2 address hit set", 6'b010000);
        acc(0);
        chk_all("R4 address hit cleared", 6'b000000);
        acc(2);
        // byte arrives after arming read: snapshot excludes it
        acc(0);
        ev(6'b001000);
        acc(2);
        chk_all("R8 flag set after read survives", 6'b001000);
        acc(0);
        // set and clear in same cycle
        ev_byte_done = 1'b1;
        rd_data = 1'b1;
        @(negedge clk);
        idle_inputs();
        chk_all("R2 set wins over clear", 6'b001000);
        acc(0);
        acc(2);
        ev(6'b000010);
        chk_all("R10 stop set", 6'b000010);
        acc(0);
        chk_all("R10 stop held by read A", 6'b000010);
        acc(1);
        chk_all("R10 stop cleared", 6'b000000);
    endtask

    task automatic t_slave_tx_nack();
        mode_rx = 1'b0;
        ev(6'b001100);
        chk_all("R2 byte+nack set", 6'b001100);
        @(negedge clk);
        acc(0);
        chk_all("R4 nack cleared", 6'b001000);
        acc(1);
        acc(3);
        chk_all("R9 bare write clears held byte", 6'b000000);
        ev(6'b000010);
        chk_all("R10 normal stop sets", 6'b000010);
        acc(1);
    endtask

    task automatic t_stop_release();
        mode_rx = 1'b0;
        ev(6'b001100);
        @(negedge clk);
        stop_ctl = 1'b1;
        @(negedge clk);
        chk_all("R9 byte held while stop bit high", 6'b001100);
        stop_ctl = 1'b0;
        @(negedge clk);
        chk_all("R9 stop bit fall clears byte", 6'b000100);
        acc(0);
        ev(6'b000010);
        chk_all("R10 released stop suppressed", 6'b000000);
        ev(6'b000010);
        chk_all("R10 next stop sets", 6'b000010);
        acc(1);
    endtask

    task automatic t_irq_gate();
        irq_en = 1'b0;
        ev(6'b010000);
        chk_all("R3 irq masked", 6'b010000);
        irq_en = 1'b1;
        #1;
        chk_all("R3 irq enabled", 6'b010000);
        acc(0);
    endtask

    initial begin
        idle_inputs();
        mode_rx = 1'b0;
        stop_ctl = 1'b0;
        irq_en = 1'b1;
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk_all("R1 initial", 6'b000000);
        t_master_tx();
        t_master_rx();
        t_slave_rx();
        t_slave_tx_nack();
        t_stop_release();
        t_irq_gate();
        t_reset();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule